// File: doc/BRIEF.md
# Event Sequencer with Error Arbitration

This block paces events through a multi-chip track-processing board. It raises a one-cycle start strobe that opens an event, then collects end-of-event markers from four upstream sources. Bits 0 and 1 of the marker input are the two detector-hit streams, and bits 2 and 3 are the two road streams. Once every source still in service has reported, the block opens the next event. A new start never overlaps an unfinished event.

The block also arbitrates error reports. Each report carries a 4-bit kind and a 4-bit mask of the faulty streams, using the same bit order as the markers. A 16-bit severity table is indexed by the kind and decides the action:
- A table bit of 1 requests a freeze. The freeze is held back until the event during which the report arrived has collected all of its markers. It is then asserted board-wide, and a one-cycle notice is sent upstream.
- A table bit of 0 removes the masked streams from service without stopping the run. Their markers are no longer awaited.

Top module: `evt_seq_arbiter`

## Requirements
- R1: After reset is released, `start_pulse` is 1 in the first cycle, and `freeze_out`, `freeze_up` and `disabled` are 0. The severity table holds its reset value `SEV_INIT`, which is 16'hFF00 by default: kinds 8 to 15 freeze and kinds 0 to 7 remove.
- R2: `start_pulse` is never high in two consecutive cycles.
- R3: An event is complete when every source either has set its sticky marker or is disabled. Suppose the last missing marker is sampled at clock edge k. Then `start_pulse` is high in the cycle that follows edge k+1, provided no freeze is active.
- R4: Markers are sticky, so order and repeats do not matter. Markers sampled while `start_pulse` is high are ignored: they do not count toward the event just opened.
- R5: An error report is accepted when `err_valid` is 1. Its action is the severity table bit at index `err_kind`: 1 means freeze and 0 means remove.
- R6: A remove action ORs `err_mask` into `disabled`, visible after the sampling edge. Bits of `disabled` never clear except at reset, and a disabled source counts as having reported.
- R7: A freeze action does not assert `freeze_out` at once. `freeze_out` rises at the same edge where the current event completes. A report sampled at the completing edge still belongs to that event. While `freeze_out` is 1, no start pulse is issued.
- R8: `freeze_up` is 1 for exactly the first cycle in which `freeze_out` is 1.
- R9: `freeze_out` stays 1 until `freeze_clr` is sampled. In the cycle after the clear, `start_pulse` is 1.
- R10: When `sev_wr` is sampled at 1, `sev_data` replaces the table. A report in the same cycle uses the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoe_in | input | NSRC | End-of-event markers: bits 1:0 are hit streams, bits 3:2 are road streams |
| err_valid | input | 1 | Error report valid |
| err_kind | input | KIND_W | Error kind, used as an index into the severity table |
| err_mask | input | NSRC | Faulty-stream mask, in the same bit order as `eoe_in` |
| sev_wr | input | 1 | Load strobe for the severity table |
| sev_data | input | 2**KIND_W | New severity table; bit i applies to kind i |
| freeze_clr | input | 1 | Releases an asserted freeze |
| start_pulse | output | 1 | One-cycle event-start strobe to all chips |
| freeze_out | output | 1 | Board-wide freeze, held until cleared |
| freeze_up | output | 1 | One-cycle freeze notice to the upstream source |
| disabled | output | NSRC | Streams removed from service |

## Verification
The hardest situation to reach is a freeze-class report that lands on the very edge at which an event completes. A close second is one that lands during the start strobe, so that it belongs to the next event. Either must move the freeze to the correct boundary. Random stimulus sends sparse reports against markers that arrive at random times, so reports fall on completing edges and start cycles many times. A directed sequence fixes the deferred case: a freeze-class kind is reported mid-event, and `freeze_out` is confirmed to stay low until the last marker has been collected.

// File: rtl/evt_seq_arbiter.sv
`timescale 1ns/1ps
module evt_seq_arbiter #(
  parameter int NSRC = 4,
  parameter int KIND_W = 4,
  parameter logic [2**KIND_W-1:0] SEV_INIT = 16'hFF00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      eoe_in,
  input  logic                 err_valid,
  input  logic [KIND_W-1:0]    err_kind,
  input  logic [NSRC-1:0]      err_mask,
  input  logic                 sev_wr,
  input  logic [2**KIND_W-1:0] sev_data,
  input  logic                 freeze_clr,
  output logic                 start_pulse,
  output logic                 freeze_out,
  output logic                 freeze_up,
  output logic [NSRC-1:0]      disabled
);
  localparam int NKIND = 2**KIND_W;

  typedef enum logic {PH_ISSUE, PH_COLLECT} phase_t;

  phase_t          phase;
  logic [NSRC-1:0] seen;
  logic [NSRC-1:0] dis;
  logic [NKIND-1:0] sev;
  logic            frz, frz_q, pend;

  wire sev_hit  = sev[err_kind];
  wire err_frz  = err_valid & sev_hit;
  wire err_rem  = err_valid & ~sev_hit;
  wire all_in   = &(seen | dis);
  wire frz_kept = frz & ~freeze_clr;

  assign start_pulse = (phase == PH_ISSUE) && !frz;
  assign freeze_out  = frz;
  assign freeze_up   = frz & ~frz_q;
  assign disabled    = dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_ISSUE;
      seen  <= '0;
      dis   <= '0;
      sev   <= SEV_INIT;
      frz   <= 1'b0;
      frz_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      frz_q <= frz;
      if (sev_wr) sev <= sev_data;
      if (err_rem) dis <= dis | err_mask;
      case (phase)
        PH_ISSUE: begin
          if (!frz) begin
            phase <= PH_COLLECT;
            seen  <= '0;
          end
          pend <= pend | err_frz;
          frz  <= frz_kept;
        end
        default: begin
          seen <= seen | eoe_in;
          if (all_in) begin
            phase <= PH_ISSUE;
            pend  <= 1'b0;
            frz   <= frz_kept | pend | err_frz;
          end else begin
            pend <= pend | err_frz;
            frz  <= frz_kept;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evt_seq_arbiter_chk.sv
`timescale 1ns/1ps
module evt_seq_arbiter_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_pulse,
  input logic            freeze_out,
  input logic            freeze_up,
  input logic            freeze_clr,
  input logic [NSRC-1:0] disabled
);
  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_no_start_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_out |-> !start_pulse);

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_out && !freeze_clr) |=> freeze_out);

  assert_up_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_out) |-> freeze_up);

  assert_up_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_up |=> !freeze_up);

  assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(disabled) & ~disabled) == '0);
endmodule

bind evt_seq_arbiter evt_seq_arbiter_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .freeze_out(freeze_out),
  .freeze_up(freeze_up), .freeze_clr(freeze_clr), .disabled(disabled)
);

// File: tb/evt_seq_arbiter_test.sv
`timescale 1ns/1ps
module evt_seq_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] eoe_in = 0, err_kind = 0, err_mask = 0;
  logic err_valid = 0, sev_wr = 0, freeze_clr = 0;
  logic [15:0] sev_data = 0;
  logic start_pulse, freeze_out, freeze_up;
  logic [3:0] disabled;

  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  bit m_collect, m_frz, m_frzq, m_pend;
  logic [3:0] m_seen, m_dis;
  logic [15:0] m_sev;

  evt_seq_arbiter uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_start();
    return !m_collect && !m_frz;
  endfunction

  task automatic model_next();
    bit hit, efrz, erem, done, kept;
    hit  = m_sev[err_kind];
    efrz = err_valid && hit;
    erem = err_valid && !hit;
    kept = m_frz && !freeze_clr;
    done = &(m_seen | m_dis);
    m_frzq = m_frz;
    if (sev_wr) m_sev = sev_data;
    if (!m_collect) begin
      if (!m_frz) begin m_collect = 1; m_seen = 0; end
      m_pend = m_pend | efrz;
      m_frz  = kept;
    end else begin
      m_seen = m_seen | eoe_in;
      if (done) begin
        m_collect = 0;
        m_frz  = kept | m_pend | efrz;
        m_pend = 0;
      end else begin
        m_pend = m_pend | efrz;
        m_frz  = kept;
      end
    end
    if (erem) m_dis = m_dis | err_mask;
  endtask

  task automatic compare();
    chk(start_pulse, exp_start(), "R3 start_pulse");
    chk(freeze_out, m_frz, "R7 freeze_out");
    chk(disabled, m_dis, "R6 disabled");
    chk(freeze_up, m_frz && !m_frzq, "R8 freeze_up");
  endtask

  task automatic step(input logic [3:0] e, input logic ev, input logic [3:0] k,
                      input logic [3:0] m, input logic sw, input logic [15:0] sd,
                      input logic clr);
    eoe_in = e; err_valid = ev; err_kind = k; err_mask = m;
    sev_wr = sw; sev_data = sd; freeze_clr = clr;
    model_next();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_collect = 0; m_frz = 0; m_frzq = 0; m_pend = 0;
    m_seen = 0; m_dis = 0; m_sev = 16'hFF00;
    chk(start_pulse, 1, "R1 start after reset");
    chk(freeze_out, 0, "R1 freeze after reset");
    chk(freeze_up, 0, "R1 freeze_up after reset");
    chk(disabled, 0, "R1 disabled after reset");

    step(0, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 0, "R2 pulse single");
    step(4'b1111, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 1, "R3 restart after four markers");
    // markers during the start cycle are dropped
    step(4'b1111, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 0, "R4 markers during start ignored");
    step(4'b0001, 0, 0, 0, 0, 0, 0);
    step(4'b0001, 0, 0, 0, 0, 0, 0);
    step(4'b0100, 0, 0, 0, 0, 0, 0);
    step(4'b1000, 0, 0, 0, 0, 0, 0);
    step(4'b0010, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 0, "R4 last marker not yet seen");
    step(0, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 1, "R4 sticky markers complete event");
    // kind 3 removes under default table
    step(0, 1, 4'd3, 4'b0010, 0, 0, 0);
    chk(disabled, 4'b0010, "R5 remove action");
    step(4'b1101, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(start_pulse, 1, "R6 disabled stream not awaited");
    // new table: kind 3 freezes; same-cycle report uses old table
    step(0, 1, 4'd3, 4'b0100, 1, 16'h0008, 0);
    chk(disabled, 4'b0110, "R10 old table in write cycle");
    step(0, 1, 4'd3, 4'b0001, 0, 0, 0);
    chk(freeze_out, 0, "R7 freeze deferred");
    chk(disabled, 4'b0110, "R10 new table freezes");
    step(4'b1001, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(freeze_out, 1, "R7 freeze at event end");
    chk(freeze_up, 1, "R8 upstream notice");
    chk(start_pulse, 0, "R7 no start while frozen");
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(freeze_out, 1, "R9 freeze held");
    step(0, 0, 0, 0, 0, 0, 1);
    chk(freeze_out, 0, "R9 freeze cleared");
    chk(start_pulse, 1, "R9 start after clear");

    for (int i = 0; i < 5000; i++) begin
      logic [3:0] e, k, m;
      logic ev, sw, clr;
      e  = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      ev = ($urandom_range(0, 15) == 0);
      k  = 4'($urandom_range(0, 15));
      m  = 4'(1 << $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) m = 0;
      sw = ($urandom_range(0, 199) == 0);
      clr = ($urandom_range(0, 7) == 0);
      step(e, ev, k, m, sw, 16'($urandom), clr);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule